// File: doc/BRIEF.md
# CAN Receive Message Queue with Word-Serial Host Reads

This block holds CAN frames that a protocol engine has finished receiving and hands them to a host one 32-bit word at a time. When the engine pulses its success strobe, the block takes the identifier, the length code and the eight data byte lanes. It also takes the current value of an internal free-running 16-bit counter. It forms a 128-bit entry from these and writes it into a circular queue.

The host drains a frame with four read strobes on a simple port. The four words come back in a fixed order, and the frame is released only when the last of the four is taken. A host read strobe on an empty queue returns no valid word and raises a sticky underflow flag. A frame that arrives while every slot is taken is dropped and raises a sticky overflow flag. A not-empty status output lets the host poll before it reads. A host write strobe on the data port is accepted and discarded.

Top module: `can_rx_word_fifo`

## Requirements
- R1: Four accepted reads of one frame return, in this order: the 32-bit identifier; a word with the timestamp in bits 31:16, the 4-bit length code in bits 15:12 and zeros in bits 11:0; data word 1 (byte 0 in bits 31:24 down to byte 3 in bits 7:0); data word 2 (byte 4 in bits 31:24 down to byte 7 in bits 7:0). On the input, byte 0 is `rx_data[63:56]` and byte 7 is `rx_data[7:0]`.
- R2: A frame leaves the queue only on its fourth accepted read. After fewer reads, `not_empty` stays high and the next read continues with the following word of the same frame.
- R3: The timestamp stored with a frame is the value of a 16-bit counter in the cycle where `rx_valid` is high. The counter is 0 in the first cycle after reset and increments by one every clock, wrapping at 16 bits.
- R4: Data bytes at positions at or beyond the length code read as zero. A length code above 8 keeps all eight bytes, and the stored length field holds the code unchanged.
- R5: A cycle with `wr_en` high is a write to the data port and has no effect, even when `rd_en` is also high. It advances no word, releases no frame and produces no `rd_valid`.
- R6: A read strobe while `not_empty` is low produces no `rd_valid` and sets `underflow_flag`.
- R7: A frame arriving while the queue holds DEPTH frames is discarded and sets `overflow_flag`. The frames already stored are unchanged.
- R8: `not_empty` is high from the cycle after a frame is stored until the cycle after that frame's fourth read, when no other frame remains.
- R9: `underflow_flag` and `overflow_flag` stay set until a cycle with `flag_clr[0]` or `flag_clr[1]` high, respectively. A new event in the same cycle as its clear keeps the flag set.
- R10: An accepted read in clock cycle k gives `rd_valid` high and the word on `rd_data` after clock edge k+1.
- R11: After reset the queue is empty, both flags are clear and `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Frame received successfully; capture the frame this cycle |
| rx_id | input | 32 | Identifier word of the received frame |
| rx_dlc | input | 4 | Length code of the received frame |
| rx_data | input | 64 | Data byte lanes, byte 0 in the top byte |
| rd_en | input | 1 | Host read strobe on the data port |
| wr_en | input | 1 | Host write strobe on the data port (discarded) |
| flag_clr | input | 2 | Bit 0 clears underflow, bit 1 clears overflow |
| rd_data | output | 32 | Word returned for a read |
| rd_valid | output | 1 | `rd_data` holds a word from an accepted read |
| not_empty | output | 1 | At least one frame is stored |
| underflow_flag | output | 1 | Sticky: a read hit an empty queue |
| overflow_flag | output | 1 | Sticky: a frame was dropped because the queue was full |

## Verification
The frame table covers length codes of 0, 1, 3, 5, 8 and 15, with byte patterns that differ in every lane. Zero-masking faults and byte-ordering faults therefore show up as wrong words. Each frame is sampled at a different counter value, so a timestamp taken one cycle early or late is detected. Directed sequences stop after three reads, mix write strobes into reads, read from an empty queue and push one frame past full. These separate early release, write leakage, underflow handling and the drop of the extra frame from reads that merely return the wrong frame.

// File: rtl/canrx_pkg.sv
package canrx_pkg;
  localparam int WORD_W     = 32;
  localparam int WORDS      = 4;
  localparam int ENTRY_W    = WORD_W * WORDS;
  localparam int TS_W       = 16;
  localparam int DLC_W      = 4;
  localparam int DATA_BYTES = 8;
  localparam int DATA_W     = DATA_BYTES * 8;
  localparam int PAD_W      = WORD_W - TS_W - DLC_W;

  // Assemble the stored entry: id, {stamp, dlc, pad}, data word 1, data word 2
  function automatic logic [ENTRY_W-1:0] build_entry(
    input logic [WORD_W-1:0] id,
    input logic [DLC_W-1:0]  dlc,
    input logic [DATA_W-1:0] data,
    input logic [TS_W-1:0]   stamp
  );
    logic [DATA_W-1:0] kept;
    int n;
    n = (int'(dlc) > DATA_BYTES) ? DATA_BYTES : int'(dlc);
    for (int b = 0; b < DATA_BYTES; b++) begin
      kept[DATA_W-1-8*b -: 8] = (b < n) ? data[DATA_W-1-8*b -: 8] : 8'h00;
    end
    return {id, stamp, dlc, {PAD_W{1'b0}}, kept};
  endfunction
endpackage

// File: rtl/canrx_stamp.sv
module canrx_stamp #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst) value <= '0;
    else     value <= value + 1'b1;
  end
endmodule

// File: rtl/canrx_ram.sv
module canrx_ram #(
  parameter int W     = 128,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  q
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    q <= mem[raddr];
  end
endmodule

// File: rtl/canrx_flags.sv
module canrx_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)         flag[g] <= 1'b0;
      else if (set[g]) flag[g] <= 1'b1;
      else if (clr[g]) flag[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/can_rx_word_fifo.sv
module can_rx_word_fifo
  import canrx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [31:0]       rx_id,
  input  logic [3:0]        rx_dlc,
  input  logic [63:0]       rx_data,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [1:0]        flag_clr,
  output logic [31:0]       rd_data,
  output logic              rd_valid,
  output logic              not_empty,
  output logic              underflow_flag,
  output logic              overflow_flag
);
  localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW     = $clog2(DEPTH + 1);
  localparam int WIDX_W = $clog2(WORDS);

  logic [TS_W-1:0]    stamp;
  logic [AW-1:0]      wptr, rptr;
  logic [CW-1:0]      count, count_next;
  logic [WIDX_W-1:0]  widx, sel_q;
  logic [ENTRY_W-1:0] ram_q;
  logic               host_rd, take, last_word, pop, full, push, drop, v1;
  logic [1:0]         flag_set, flag_q;
  logic [WORD_W-1:0]  words [WORDS];

  canrx_stamp #(.W(TS_W)) u_stamp (.clk(clk), .rst(rst), .value(stamp));

  assign host_rd   = rd_en & ~wr_en;
  assign take      = host_rd & not_empty;
  assign last_word = (widx == WIDX_W'(WORDS - 1));
  assign pop       = take & last_word;
  assign full      = (count == CW'(DEPTH));
  assign push      = rx_valid & ~full;
  assign drop      = rx_valid & full;

  always_comb begin
    count_next = count;
    if (push && !pop)      count_next = count + 1'b1;
    else if (pop && !push) count_next = count - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr      <= '0;
      rptr      <= '0;
      count     <= '0;
      widx      <= '0;
      not_empty <= 1'b0;
    end else begin
      count     <= count_next;
      not_empty <= (count_next != '0);
      if (push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      if (take) widx <= widx + 1'b1;
    end
  end

  canrx_ram #(.W(ENTRY_W), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (push),
    .waddr (wptr),
    .wdata (build_entry(rx_id, rx_dlc, rx_data, stamp)),
    .raddr (rptr),
    .q     (ram_q)
  );

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    assign words[g] = ram_q[ENTRY_W-1-WORD_W*g -: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= '0;
      v1       <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      sel_q    <= widx;
      v1       <= take;
      rd_data  <= words[sel_q];
      rd_valid <= v1;
    end
  end

  assign flag_set = {drop, host_rd & ~not_empty};

  canrx_flags #(.N(2)) u_flags (
    .clk (clk), .rst (rst), .set (flag_set), .clr (flag_clr), .flag (flag_q)
  );

  assign underflow_flag = flag_q[0];
  assign overflow_flag  = flag_q[1];
endmodule

// File: rtl/canrx_checker.sv
module canrx_checker #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          rd_en,
  input logic          wr_en,
  input logic          rx_valid,
  input logic [1:0]    flag_clr,
  input logic          rd_valid,
  input logic          not_empty,
  input logic          underflow_flag,
  input logic          overflow_flag,
  input logic [CW-1:0] level
);
  // R10: accepted read gives a word two edges later
  a_r10_read_latency: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && not_empty) |=> ##1 rd_valid);

  // R6: read of empty queue raises underflow and yields no word
  a_r6_underflow_set: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && !not_empty) |=> underflow_flag);
  a_r6_no_word: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !not_empty) |=> ##1 !rd_valid);

  // R5: write strobe changes nothing
  a_r5_write_no_pop: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rx_valid) |=> $stable(not_empty));
  a_r5_write_no_word: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ##1 !rd_valid);

  // R7: arrival on a full queue sets overflow and keeps the level
  a_r7_overflow_set: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && level == CW'(DEPTH)) |=> overflow_flag);
  a_r7_no_growth: assert property (@(posedge clk) disable iff (rst)
    (level == CW'(DEPTH)) |=> (level <= CW'(DEPTH)));

  // R9: flags are sticky without a clear
  a_r9_underflow_sticky: assert property (@(posedge clk) disable iff (rst)
    (underflow_flag && !flag_clr[0]) |=> underflow_flag);
  a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
    (overflow_flag && !flag_clr[1]) |=> overflow_flag);

  // R11: reset leaves an empty, quiet block
  a_r11_reset_state: assert property (@(posedge clk)
    rst |=> (!not_empty && !rd_valid && !underflow_flag && !overflow_flag));
endmodule

bind can_rx_word_fifo canrx_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .rd_en          (rd_en),
  .wr_en          (wr_en),
  .rx_valid       (rx_valid),
  .flag_clr       (flag_clr),
  .rd_valid       (rd_valid),
  .not_empty      (not_empty),
  .underflow_flag (underflow_flag),
  .overflow_flag  (overflow_flag),
  .level          (count)
);

// File: tb/can_rx_word_fifo_test.sv
module can_rx_word_fifo_test;
  localparam int DEPTH = 8;
  localparam int NVEC  = 6;

  // vector: {id[31:0], dlc[3:0], data[63:0]}
  localparam logic [99:0] VEC [NVEC] = '{
    {32'h1234_5678, 4'd8,  64'h0102_0304_0506_0708},
    {32'h8000_0ABC, 4'd0,  64'hFFEE_DDCC_BBAA_9988},
    {32'h0000_07FF, 4'd3,  64'hA1B2_C3D4_E5F6_0718},
    {32'hDEAD_BEEF, 4'd5,  64'h1122_3344_5566_7788},
    {32'h1FFF_FFFF, 4'd15, 64'hCAFE_F00D_8BAD_F00D},
    {32'h0000_0001, 4'd1,  64'h7F00_0000_0000_00FF}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_valid = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [31:0] rx_id = '0;
  logic [3:0]  rx_dlc = '0;
  logic [63:0] rx_data = '0;
  logic [1:0]  flag_clr = '0;
  logic [31:0] rd_data;
  logic rd_valid, not_empty, underflow_flag, overflow_flag;
  logic [15:0] tb_stamp = '0;
  int n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  // R3: counter model: 0 after reset, +1 every clock
  always @(posedge clk) tb_stamp <= rst ? 16'd0 : tb_stamp + 16'd1;

  can_rx_word_fifo #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_id(rx_id), .rx_dlc(rx_dlc),
    .rx_data(rx_data), .rd_en(rd_en), .wr_en(wr_en), .flag_clr(flag_clr),
    .rd_data(rd_data), .rd_valid(rd_valid), .not_empty(not_empty),
    .underflow_flag(underflow_flag), .overflow_flag(overflow_flag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] masked(input logic [3:0] dlc, input logic [63:0] d);
    logic [63:0] r = '0;
    int keep = (dlc > 4'd8) ? 8 : int'(dlc);
    for (int b = 0; b < keep; b++) r[63-8*b -: 8] = d[63-8*b -: 8];
    return r;
  endfunction

  task automatic push(input logic [31:0] id, input logic [3:0] dlc,
                      input logic [63:0] d, output logic [15:0] ts);
    @(negedge clk);
    rx_id = id; rx_dlc = dlc; rx_data = d; rx_valid = 1'b1;
    ts = tb_stamp;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic read_word(output logic [31:0] d, output logic v);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    @(negedge clk); d = rd_data; v = rd_valid;
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [31:0] w;
    logic v;
    logic [15:0] ts;
    logic [63:0] m;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11 not_empty", {31'd0, not_empty}, 32'd0);
    check("R11 flags", {30'd0, underflow_flag, overflow_flag}, 32'd0);
    check("R11 rd_valid", {31'd0, rd_valid}, 32'd0);

    // Table walk: R1, R3, R4, R8, R10
    for (int i = 0; i < NVEC; i++) begin
      push(VEC[i][99:68], VEC[i][67:64], VEC[i][63:0], ts);
      check("R8 not_empty after store", {31'd0, not_empty}, 32'd1);
      m = masked(VEC[i][67:64], VEC[i][63:0]);
      read_word(w, v);
      check("R10 rd_valid", {31'd0, v}, 32'd1);
      check("R1 identifier word", w, VEC[i][99:68]);
      read_word(w, v);
      check("R3 timestamp/length word", w, {ts, VEC[i][67:64], 12'h000});
      read_word(w, v);
      check("R4 data word 1", w, m[63:32]);
      read_word(w, v);
      check("R4 data word 2", w, m[31:0]);
      check("R8 empty after fourth read", {31'd0, not_empty}, 32'd0);
      repeat (i) @(negedge clk);
    end

    // R6 underflow on empty read, R9 sticky then cleared
    read_word(w, v);
    check("R6 no rd_valid on empty", {31'd0, v}, 32'd0);
    check("R6 underflow set", {31'd0, underflow_flag}, 32'd1);
    repeat (3) @(negedge clk);
    check("R9 underflow sticky", {31'd0, underflow_flag}, 32'd1);
    flag_clr = 2'b01;
    @(negedge clk); flag_clr = 2'b00;
    check("R9 underflow cleared", {31'd0, underflow_flag}, 32'd0);

    // R5 write strobes ignored, R2 release only after fourth read
    push(32'hCAFE_0005, 4'd2, 64'hAB00_0000_0000_0000, ts);
    @(negedge clk); rd_en = 1'b1; wr_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    @(negedge clk); wr_en = 1'b0;
    check("R5 no rd_valid on write", {31'd0, rd_valid}, 32'd0);
    check("R5 frame kept", {31'd0, not_empty}, 32'd1);
    read_word(w, v);
    check("R5 word index unchanged", w, 32'hCAFE_0005);
    read_word(w, v);
    read_word(w, v);
    check("R4 masked data", w, 32'hAB00_0000);
    check("R2 held after third read", {31'd0, not_empty}, 32'd1);
    read_word(w, v);
    check("R2 released after fourth read", {31'd0, not_empty}, 32'd0);

    // R7 overflow: fill, one extra, drain
    for (int i = 0; i < DEPTH; i++) push(32'd100 + 32'(i), 4'd0, 64'd0, ts);
    check("R7 no overflow while filling", {31'd0, overflow_flag}, 32'd0);
    push(32'd999, 4'd0, 64'd0, ts);
    check("R7 overflow set", {31'd0, overflow_flag}, 32'd1);
    for (int i = 0; i < DEPTH; i++) begin
      read_word(w, v);
      check("R7 stored frame kept", w, 32'd100 + 32'(i));
      for (int k = 0; k < 3; k++) read_word(w, v);
    end
    check("R7 extra frame discarded", {31'd0, not_empty}, 32'd0);
    flag_clr = 2'b10;
    @(negedge clk); flag_clr = 2'b00;
    check("R9 overflow cleared", {31'd0, overflow_flag}, 32'd0);

    finish_up();
  end
endmodule